// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR SDRAM and drives the command bus from power-up to the point where normal traffic may begin. After `start` is raised, it holds the clock-enable low and keeps the device deselected for a power-up wait. The wait is given in microseconds and turned into clock cycles from the clock period parameter. The block then raises the clock-enable and steps through a fixed, ordered series of commands: precharge of all banks, a load of the extended mode register, a load of the base mode register with the DLL reset bit set, a second precharge of all banks, two auto refreshes, and a final base mode register load with the DLL reset bit cleared.

Each command lasts one cycle. NOP cycles follow it, so the next command starts no sooner than the precharge, mode-load or refresh recovery time allows. All of these times are cycle-count parameters. The two mode register values are inputs. The block adds the DLL reset bit itself, setting it in the first base load and clearing it in the final one. `done` rises only when the final load's recovery time has elapsed and the DLL lock count since the DLL reset load has also run out. Reads are therefore held off until then. Lowering `start` at any point aborts the sequence and returns the block to idle.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is active, or on every cycle after an edge where `start` was sampled low, the bus is idle: `cke`=0, {cs_n,ras_n,cas_n,we_n}=1111, `ba`=0, `addr`=0, `done`=0.
- R2: Number the cycles from the clock edge where `start` is first sampled high as t=0. For t < P, where P = ceil(PWRUP_US·10^6 / CLK_PERIOD_PS), the bus stays idle with `cke` low.
- R3: At t = P, `cke` is 1 and the command is NOP, {cs_n,ras_n,cas_n,we_n}=0111.
- R4: A precharge-all command (0010, with address bit AP_BIT=10 set and all other address bits 0, `ba`=00) is issued at t = P+1, and again one mode-load gap after the DLL reset load.
- R5: The extended mode load (0000) is issued T_RP_CYC cycles after the first precharge, with `ba`=01 and `addr`=`ext_mode`.
- R6: The base mode load with DLL reset is issued T_MRD_CYC cycles after the extended load, with `ba`=00 and `addr`=`base_mode` with bit DLL_RST_BIT (8) forced to 1.
- R7: Every cycle between commands, from t = P onward, is a NOP with `cke` high, `ba`=0 and `addr`=0. Consecutive commands are exactly T_RP_CYC apart after a precharge, T_MRD_CYC after a mode load, and T_RFC_CYC after a refresh.
- R8: Two auto refresh commands (0001, `addr`=0) follow the second precharge, one T_RP_CYC after it and the next T_RFC_CYC after the first.
- R9: T_RFC_CYC cycles after the second refresh, the final base load (0000, `ba`=00) is issued with `addr`=`base_mode` with bit DLL_RST_BIT forced to 0.
- R10: `done` first rises on cycle max(f+T_MRD_CYC, m+T_DLL_LOCK_CYC+1), where f is the final load cycle and m is the DLL reset load cycle. It is never high earlier.
- R11: Lowering `start` mid-sequence returns the bus to idle on the next cycle with `done` low, and a later `start` replays the whole sequence from t=0.
- R12: Once high, `done` stays high with a NOP on the bus and `cke` high for as long as `start` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Level request to run (and keep) the initialization |
| ext_mode | input | AW | Value for the extended mode register load |
| base_mode | input | AW | Operating parameters for the base mode register loads |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | AW | Address bus |
| done | output | 1 | Memory ready for normal traffic, reads allowed |

## Verification
Every state of the sequencer maps to one exact bus pattern on one exact cycle. A wrong state, a step timer off by one or a slip in the lock count therefore shows up on the command pins on the very cycle it occurs: a command appears one cycle early or late, a NOP appears where a command should be, or `ba`/`addr` carry the wrong value. A lock counter that saturates too early or too late moves the rising edge of `done`. This is checked against the timing formula in two builds. In one the DLL lock count dominates, and in the other the final mode-load recovery dominates.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_CKE_NOP,
    ST_PRE1,
    ST_EXT_LOAD,
    ST_DLLRST_LOAD,
    ST_PRE2,
    ST_REF1,
    ST_REF2,
    ST_FINAL_LOAD,
    ST_LOCK_WAIT,
    ST_READY
  } init_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } ddr_cmd_e;

  function automatic int unsigned ceil_cycles(int unsigned us, int unsigned period_ps);
    return (us * 1000000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                          int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/init_step_timer.sv
module init_step_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  assert_timer_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0))
    else $error("step timer left zero without a load");

endmodule

// File: rtl/init_lock_cnt.sv
module init_lock_cnt #(
  parameter int unsigned LIMIT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic arm_i,
  output logic expired_o
);

  localparam int unsigned LW = $clog2(LIMIT + 1);
  localparam logic [LW-1:0] LIM = LW'(LIMIT);

  logic          armed_q;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      cnt_q   <= LW'(1);
    end else if (armed_q && cnt_q < LIM) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign expired_o = armed_q && (cnt_q >= LIM);

  assert_lock_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !arm_i && !clear_i) |=> expired_o)
    else $error("DLL lock expiry dropped without clear");

endmodule

// File: rtl/init_cmd_enc.sv
module init_cmd_enc
  import ddr_init_pkg::*;
#(
  parameter int unsigned AW          = 12,
  parameter int unsigned DLL_RST_BIT = 8,
  parameter int unsigned AP_BIT      = 10
) (
  input  init_state_e   state_i,
  input  logic          fresh_i,
  input  logic [AW-1:0] ext_mode_i,
  input  logic [AW-1:0] base_mode_i,
  output logic          cke_o,
  output ddr_cmd_e      cmd_o,
  output logic [1:0]    ba_o,
  output logic [AW-1:0] addr_o
);

  localparam logic [AW-1:0] DLL_MASK = AW'(1) << DLL_RST_BIT;
  localparam logic [AW-1:0] AP_MASK  = AW'(1) << AP_BIT;

  always_comb begin
    cke_o  = 1'b1;
    cmd_o  = CMD_NOP;
    ba_o   = 2'b00;
    addr_o = '0;
    unique case (state_i)
      ST_IDLE, ST_PWRUP: begin
        cke_o = 1'b0;
        cmd_o = CMD_DESEL;
      end
      ST_PRE1, ST_PRE2: if (fresh_i) begin
        cmd_o  = CMD_PRE;
        addr_o = AP_MASK;
      end
      ST_EXT_LOAD: if (fresh_i) begin
        cmd_o  = CMD_LMR;
        ba_o   = 2'b01;
        addr_o = ext_mode_i;
      end
      ST_DLLRST_LOAD: if (fresh_i) begin
        cmd_o  = CMD_LMR;
        addr_o = base_mode_i | DLL_MASK;
      end
      ST_REF1, ST_REF2: if (fresh_i) cmd_o = CMD_REF;
      ST_FINAL_LOAD: if (fresh_i) begin
        cmd_o  = CMD_LMR;
        addr_o = base_mode_i & ~DLL_MASK;
      end
      default: ;
    endcase
    assert_lmr_bank_R5: assert (cmd_o != CMD_LMR || ba_o[1] == 1'b0)
      else $error("mode load with BA1 set");
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int unsigned AW             = 12,
  parameter int unsigned CLK_PERIOD_PS  = 5000,
  parameter int unsigned PWRUP_US       = 200,
  parameter int unsigned T_RP_CYC       = 3,
  parameter int unsigned T_MRD_CYC      = 2,
  parameter int unsigned T_RFC_CYC      = 15,
  parameter int unsigned T_DLL_LOCK_CYC = 200,
  parameter int unsigned DLL_RST_BIT    = 8,
  parameter int unsigned AP_BIT         = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] ext_mode,
  input  logic [AW-1:0] base_mode,
  output logic          cke,
  output logic          cs_n,
  output logic          ras_n,
  output logic          cas_n,
  output logic          we_n,
  output logic [1:0]    ba,
  output logic [AW-1:0] addr,
  output logic          done
);

  localparam int unsigned PWRUP_CYC = ceil_cycles(PWRUP_US, CLK_PERIOD_PS);
  localparam int unsigned GAP_MAX   = max_of4(PWRUP_CYC, T_RP_CYC, T_MRD_CYC, T_RFC_CYC);
  localparam int unsigned TW        = $clog2(GAP_MAX + 1);

  // Cycles a state occupies: its command cycle plus trailing NOPs.
  function automatic int unsigned step_len(init_state_e s);
    case (s)
      ST_PWRUP:                                  return PWRUP_CYC;
      ST_PRE1, ST_PRE2:                          return T_RP_CYC;
      ST_EXT_LOAD, ST_DLLRST_LOAD, ST_FINAL_LOAD: return T_MRD_CYC;
      ST_REF1, ST_REF2:                          return T_RFC_CYC;
      default:                                   return 1;
    endcase
  endfunction

  init_state_e   state_q, state_d;
  logic          fresh_q;
  logic          step_zero;
  logic          lock_exp;
  logic          step_load;
  logic          dll_arm;
  logic          lock_clear;
  logic [TW-1:0] step_val;
  ddr_cmd_e      cmd;

  always_comb begin
    state_d = state_q;
    if (!start) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:        state_d = ST_PWRUP;
        ST_PWRUP:       if (step_zero) state_d = ST_CKE_NOP;
        ST_CKE_NOP:     if (step_zero) state_d = ST_PRE1;
        ST_PRE1:        if (step_zero) state_d = ST_EXT_LOAD;
        ST_EXT_LOAD:    if (step_zero) state_d = ST_DLLRST_LOAD;
        ST_DLLRST_LOAD: if (step_zero) state_d = ST_PRE2;
        ST_PRE2:        if (step_zero) state_d = ST_REF1;
        ST_REF1:        if (step_zero) state_d = ST_REF2;
        ST_REF2:        if (step_zero) state_d = ST_FINAL_LOAD;
        ST_FINAL_LOAD:  if (step_zero) state_d = lock_exp ? ST_READY : ST_LOCK_WAIT;
        ST_LOCK_WAIT:   if (lock_exp)  state_d = ST_READY;
        ST_READY:       state_d = ST_READY;
        default:        state_d = ST_IDLE;
      endcase
    end
  end

  assign step_load  = (state_d != state_q);
  assign step_val   = TW'(step_len(state_d) - 1);
  assign dll_arm    = (state_q == ST_DLLRST_LOAD) && fresh_q;
  assign lock_clear = (state_q == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fresh_q <= 1'b0;
    end else begin
      state_q <= state_d;
      fresh_q <= step_load;
    end
  end

  init_step_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (step_load),
    .load_val_i (step_val),
    .zero_o     (step_zero)
  );

  init_lock_cnt #(.LIMIT(T_DLL_LOCK_CYC)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (lock_clear),
    .arm_i     (dll_arm),
    .expired_o (lock_exp)
  );

  init_cmd_enc #(.AW(AW), .DLL_RST_BIT(DLL_RST_BIT), .AP_BIT(AP_BIT)) u_enc (
    .state_i     (state_q),
    .fresh_i     (fresh_q),
    .ext_mode_i  (ext_mode),
    .base_mode_i (base_mode),
    .cke_o       (cke),
    .cmd_o       (cmd),
    .ba_o        (ba),
    .addr_o      (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign done = (state_q == ST_READY);

  assert_pwrup_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWRUP) |-> (!cke && cs_n))
    else $error("bus active during power-up wait");

  assert_cke_rise_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (!cs_n && ras_n && cas_n && we_n))
    else $error("clock enable rose without a NOP");

  assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lock_exp)
    else $error("ready before DLL lock count expired");

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && !cke))
    else $error("not idle after start dropped");

  assert_ready_nop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cke && !cs_n && ras_n && cas_n && we_n))
    else $error("ready without NOP on the bus");

endmodule

// File: tb/tb_ddr_init_seq.sv
module tb_ddr_init_seq;

  // 50 MHz clock; power-up wait of 1 us -> 50 cycles in both builds.
  localparam int P_CYC = 50;
  localparam int RP    = 3;
  localparam int MRD   = 2;
  localparam int RFC_A = 8;
  localparam int LK_A  = 200;
  localparam int RFC_B = 5;
  localparam int LK_B  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [11:0] ext_v = 12'h000;
  logic [11:0] base_v = 12'h000;

  always #10 clk = ~clk;

  logic cke_a, cs_a, ras_a, cas_a, we_a, done_a;
  logic [1:0] ba_a;
  logic [11:0] addr_a;
  logic cke_b, cs_b, ras_b, cas_b, we_b, done_b;
  logic [1:0] ba_b;
  logic [11:0] addr_b;

  ddr_init_seq #(.CLK_PERIOD_PS(20000), .PWRUP_US(1), .T_RP_CYC(RP), .T_MRD_CYC(MRD),
                 .T_RFC_CYC(RFC_A), .T_DLL_LOCK_CYC(LK_A)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_mode(ext_v), .base_mode(base_v),
    .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a), .cas_n(cas_a), .we_n(we_a),
    .ba(ba_a), .addr(addr_a), .done(done_a));

  ddr_init_seq #(.CLK_PERIOD_PS(20000), .PWRUP_US(1), .T_RP_CYC(RP), .T_MRD_CYC(MRD),
                 .T_RFC_CYC(RFC_B), .T_DLL_LOCK_CYC(LK_B)) dut_b (
    .clk(clk), .rst_n(rst_n), .start(start), .ext_mode(ext_v), .base_mode(base_v),
    .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b), .cas_n(cas_b), .we_n(we_b),
    .ba(ba_b), .addr(addr_b), .done(done_b));

  int n_chk = 0;
  int n_fail = 0;
  int t_run = -1;   // cycles since start was first sampled high, -1 when idle

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       t_run <= -1;
    else if (!start)  t_run <= -1;
    else              t_run <= (t_run < 0) ? 0 : t_run + 1;
  end

  // Expected {cke, cs_n, ras_n, cas_n, we_n, ba, addr, done}
  function automatic logic [19:0] model_bus(int t, int rfc, int lk,
                                            logic [11:0] ext, logic [11:0] base);
    int e, m, p2, r1, r2, f, d;
    if (t < P_CYC) return {1'b0, 4'b1111, 2'b00, 12'h000, 1'b0};
    e = P_CYC + 1 + RP; m = e + MRD; p2 = m + MRD;
    r1 = p2 + RP; r2 = r1 + rfc; f = r2 + rfc;
    d = (f + MRD > m + lk + 1) ? f + MRD : m + lk + 1;
    if (t == P_CYC + 1 || t == p2) return {1'b1, 4'b0010, 2'b00, 12'h400, 1'b0};
    if (t == e)  return {1'b1, 4'b0000, 2'b01, ext, 1'b0};
    if (t == m)  return {1'b1, 4'b0000, 2'b00, base | 12'h100, 1'b0};
    if (t == r1 || t == r2) return {1'b1, 4'b0001, 2'b00, 12'h000, 1'b0};
    if (t == f)  return {1'b1, 4'b0000, 2'b00, base & ~12'h100, 1'b0};
    return {1'b1, 4'b0111, 2'b00, 12'h000, (t >= d)};
  endfunction

  function automatic string req_tag(int t, int rfc, int lk);
    int e, m, p2, r1, r2, f, d;
    e = P_CYC + 1 + RP; m = e + MRD; p2 = m + MRD;
    r1 = p2 + RP; r2 = r1 + rfc; f = r2 + rfc;
    d = (f + MRD > m + lk + 1) ? f + MRD : m + lk + 1;
    if (t < 0)                      return "R1/R11 idle";
    if (t < P_CYC)                  return "R2 power-up wait";
    if (t == P_CYC)                 return "R3 cke NOP";
    if (t == P_CYC + 1 || t == p2)  return "R4 precharge all";
    if (t == e)                     return "R5 extended load";
    if (t == m)                     return "R6 DLL reset load";
    if (t == r1 || t == r2)         return "R8 refresh";
    if (t == f)                     return "R9 final load";
    if (t == d || t == d - 1)       return "R10 ready edge";
    if (t > d)                      return "R12 ready hold";
    return "R7 NOP gap";
  endfunction

  task automatic check_one(string who, int rfc, int lk, logic [19:0] act);
    logic [19:0] exp;
    exp = model_bus(t_run, rfc, lk, ext_v, base_v);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s t=%0d actual=%05h expected=%05h",
               who, req_tag(t_run, rfc, lk), t_run, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check_one("dut",   RFC_A, LK_A,
              {cke_a, cs_a, ras_a, cas_a, we_a, ba_a, addr_a, done_a});
    check_one("dut_b", RFC_B, LK_B,
              {cke_b, cs_b, ras_b, cas_b, we_b, ba_b, addr_b, done_b});
  end

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog (all R) actual=hung expected=finished");
    finish_run();
  end

  initial begin
    // R1: reset state, then idle with start low
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Full run 1: lock count dominates in dut, final-load gap in dut_b (R2..R10, R12)
    ext_v  = 12'h000;
    base_v = 12'h062;
    start  = 1'b1;
    repeat (266) @(negedge clk);
    start  = 1'b0;            // R1/R11: ready drops, bus idle
    repeat (4) @(negedge clk);

    // R11: abort in the middle of the command series
    ext_v  = 12'h002;
    base_v = 12'h021;
    start  = 1'b1;
    repeat (58) @(negedge clk);
    start  = 1'b0;
    repeat (4) @(negedge clk);

    // Full run 2: new mode values, DLL bit already set in base (R6, R9)
    ext_v  = 12'h5A1;
    base_v = 12'h3A5;
    start  = 1'b1;
    repeat (266) @(negedge clk);

    // Reset in the middle of ready (R1)
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule